// File: doc/BRIEF.md
# Programmable Timer with Reference Compare

This block is a 16-bit up-counting timer with a small register port. The count advances on a tick that comes from a two-stage divider. The first stage either passes the system clock through or divides it by a fixed 16. The second stage is a programmable 8-bit prescaler that divides by its setting plus one. Each time the count equals a programmed reference, a sticky event flag is set. The count can then return to zero or keep going, and an interrupt line rises if the interrupt is enabled.

Software reaches the block through a synchronous port that has a byte address, a write strobe, write data and combinational read data. Writing the control word or the reference restarts the divider and the count with the new settings. A separate write loads the count directly. The event flags are cleared by writing ones to them.

Top module: `ref_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register offsets: control word at 0x00, reference at 0x04, capture word at 0x08, count at 0x0C, event flags at 0x11 (bits 1:0 of the data bus). Any other offset reads zero. The capture word is plain storage that reads back what was last written.
- R3: Control bit 0 is the run enable. A control write that takes bit 0 from 1 to 0 leaves both the control word and the reference at zero. Writing a disabled value while already disabled stores it as written. While bit 0 is clear, the count holds.
- R4: Control bits 2:1 select the tick source. A value of 1 uses the system clock and a value of 2 uses the system clock divided by 16. The values 0 and 3 stop the count.
- R5: Control bits 15:8 hold a prescale value P. The count advances once every (P+1) cycles of the selected source, so the first advance comes (P+1) or 16*(P+1) cycles after a restart.
- R6: When control bit 3 is set, a tick that finds the count equal to the reference returns the count to zero, which gives a period of reference+1 ticks.
- R7: When control bit 3 is clear, the count runs through the reference, wraps from 0xFFFF to 0, and still flags the reference event.
- R8: A tick that finds the count equal to the reference sets event bit 1. The bit stays set until a write to 0x11 with data bit 1 set. Writing a zero there changes nothing.
- R9: `irq` is high exactly while control bit 4 and event bit 1 are both set.
- R10: A write to 0x0C loads the count without restarting the prescaler. A read of 0x0C returns the present count.
- R11: A write to the control word or to the reference sets the count to zero and restarts both divider stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Reference interrupt |

## Verification
The bench targets the exact cycle of the first tick after a restart. It does this under both tick sources and several prescale values, because a divider that is off by one shifts every count it reads. It drives the count across 0xFFFF in free-running mode: a design that saturated, or that lost the reference event on the wrap, would read the wrong count or show a clear flag. It checks that a disabling write zeroes the reference while a disabled-to-disabled write does not, and that writing zeros to the event register leaves the flag and `irq` set. Randomized reference, mode and wait-length runs compare the count, the event and `irq` against a tick-by-tick model in the bench.

// File: rtl/ref_timer_pkg.sv
package ref_timer_pkg;
   // register byte offsets
   localparam int OFS_MODE = 'h00;
   localparam int OFS_REF  = 'h04;
   localparam int OFS_CAP  = 'h08;
   localparam int OFS_CNT  = 'h0C;
   localparam int OFS_EVT  = 'h11;

   // control word field positions
   localparam int MB_EN      = 0;
   localparam int MB_SEL_LO  = 1;
   localparam int MB_RESTART = 3;
   localparam int MB_IRQEN   = 4;
   localparam int MB_PS_LO   = 8;

   typedef enum logic [1:0] {
      SRC_OFF0  = 2'd0,
      SRC_SYS   = 2'd1,
      SRC_SYS16 = 2'd2,
      SRC_OFF3  = 2'd3
   } src_sel_e;
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
   parameter int PS_W         = 8,
   parameter int FIX_DIV_LOG2 = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            run,
   input  logic            use_slow,
   input  logic [PS_W-1:0] ps_val,
   output logic            tick
);
   logic stage_en;
   logic [PS_W-1:0] ps_q;

   generate
      if (FIX_DIV_LOG2 > 0) begin : g_fixdiv
         logic [FIX_DIV_LOG2-1:0] fix_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              fix_q <= '0;
            else if (restart)        fix_q <= '0;
            else if (run && use_slow) fix_q <= fix_q + 1'b1;
         end
         assign stage_en = run && !restart && (!use_slow || (&fix_q));
      end else begin : g_nofixdiv
         assign stage_en = run && !restart;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)        ps_q <= '0;
      else if (restart)  ps_q <= ps_val;
      else if (stage_en) ps_q <= (ps_q == '0) ? ps_val : ps_q - 1'b1;
   end

   assign tick = stage_en && (ps_q == '0);
endmodule

// File: rtl/rt_count.sv
module rt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic             wrap_on_ref,
   input  logic [CNT_W-1:0] ref_val,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [1:0]       evt_clr,
   output logic [CNT_W-1:0] count,
   output logic [1:0]       evt
);
   logic hit;
   assign hit = tick && !restart && !load && (count == ref_val);

   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (load)    count <= load_val;
      else if (restart) count <= '0;
      else if (tick)    count <= (hit && wrap_on_ref) ? '0 : count + 1'b1;
   end

   // set wins over a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n) evt <= '0;
      else        evt <= (evt & ~evt_clr) | {hit, 1'b0};
   end
endmodule

// File: rtl/ref_timer.sv
module ref_timer
   import ref_timer_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int PS_W         = 8,
   parameter int FIX_DIV_LOG2 = 4,
   parameter int ADDR_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic              irq
);
   generate
      if (MB_PS_LO + PS_W > CNT_W) begin : g_bad_ps
         $error("prescale field does not fit in the control word");
      end
      if ((1 << ADDR_W) <= OFS_EVT) begin : g_bad_addr
         $error("address too narrow for the register map");
      end
   endgenerate

   logic [CNT_W-1:0] mode_q, ref_q, cap_q, mode_nxt;
   logic [CNT_W-1:0] count_w;
   logic [1:0]       evt_w;
   logic             tick_w;
   logic             wr_mode, wr_ref, wr_cap, wr_cnt, wr_evt, dis_clr, restart;
   src_sel_e         sel;

   assign wr_mode = wr_en && (addr == ADDR_W'(OFS_MODE));
   assign wr_ref  = wr_en && (addr == ADDR_W'(OFS_REF));
   assign wr_cap  = wr_en && (addr == ADDR_W'(OFS_CAP));
   assign wr_cnt  = wr_en && (addr == ADDR_W'(OFS_CNT));
   assign wr_evt  = wr_en && (addr == ADDR_W'(OFS_EVT));
   assign dis_clr = wr_mode && mode_q[MB_EN] && !wdata[MB_EN];
   assign restart = wr_mode || wr_ref;

   always_comb begin
      mode_nxt = mode_q;
      if (wr_mode) mode_nxt = dis_clr ? '0 : wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         ref_q  <= '0;
         cap_q  <= '0;
      end else begin
         mode_q <= mode_nxt;
         if (wr_ref)       ref_q <= wdata;
         else if (dis_clr) ref_q <= '0;
         if (wr_cap)       cap_q <= wdata;
      end
   end

   assign sel = src_sel_e'(mode_q[MB_SEL_LO +: 2]);

   rt_prescaler #(.PS_W(PS_W), .FIX_DIV_LOG2(FIX_DIV_LOG2)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .run      (mode_q[MB_EN] && (sel == SRC_SYS || sel == SRC_SYS16)),
      .use_slow (sel == SRC_SYS16),
      .ps_val   (mode_nxt[MB_PS_LO +: PS_W]),
      .tick     (tick_w)
   );

   rt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (restart),
      .tick        (tick_w),
      .wrap_on_ref (mode_q[MB_RESTART]),
      .ref_val     (ref_q),
      .load        (wr_cnt),
      .load_val    (wdata),
      .evt_clr     (wr_evt ? wdata[1:0] : 2'b00),
      .count       (count_w),
      .evt         (evt_w)
   );

   always_comb begin
      case (addr)
         ADDR_W'(OFS_MODE): rdata = mode_q;
         ADDR_W'(OFS_REF):  rdata = ref_q;
         ADDR_W'(OFS_CAP):  rdata = cap_q;
         ADDR_W'(OFS_CNT):  rdata = count_w;
         ADDR_W'(OFS_EVT):  rdata = {{(CNT_W-2){1'b0}}, evt_w};
         default:           rdata = '0;
      endcase
   end

   assign irq = mode_q[MB_IRQEN] && evt_w[1];
endmodule

// File: rtl/ref_timer_chk.sv
module ref_timer_chk #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  wdata,
   input logic              irq,
   input logic [CNT_W-1:0]  mode_q,
   input logic [CNT_W-1:0]  ref_q,
   input logic [CNT_W-1:0]  count_q,
   input logic [1:0]        evt_q,
   input logic              tick
);
   // R3: a disabling control write zeroes control and reference
   a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'('h00) && mode_q[0] && !wdata[0])
      |=> (mode_q == '0 && ref_q == '0));

   // R3: count holds while disabled and no write
   a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[0] && !wr_en) |=> $stable(count_q));

   // R4: stopped tick sources freeze the count
   a_r4_stopped_src: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q[2:1] == 2'd0 || mode_q[2:1] == 2'd3) && !wr_en) |=> $stable(count_q));

   // R6: match with restart returns to zero
   a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode_q[3] && count_q == ref_q && !wr_en) |=> (count_q == '0));

   // R8: the reference event is sticky until a one is written to it
   a_r8_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[1] && !(wr_en && addr == ADDR_W'('h11) && wdata[1])) |=> evt_q[1]);

   // R9: no interrupt while its enable is clear
   a_r9_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[4] |-> !irq);

   // R10: a count write loads the written value
   a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'('h0C)) |=> (count_q == $past(wdata)));
endmodule

bind ref_timer ref_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .irq     (irq),
   .mode_q  (mode_q),
   .ref_q   (ref_q),
   .count_q (count_w),
   .evt_q   (evt_w),
   .tick    (tick_w)
);

// File: tb/ref_timer_tb_top.sv
module ref_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   ref_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      addr = 5'(a); wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      addr = 5'(a);
      #1;
      v = rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // tick-by-tick count model from the requirements
   function automatic void model(input int start, input int ticks, input int r, input bit rr,
                                 output int c, output bit hit);
      c = start; hit = 1'b0;
      for (int t = 0; t < ticks; t++) begin
         if (c == r) begin
            hit = 1'b1;
            c = rr ? 0 : ((c + 1) & 16'hFFFF);
         end else c = (c + 1) & 16'hFFFF;
      end
   endfunction

   function automatic logic [15:0] mk_mode(input int ps, input int sel, input bit rr,
                                           input bit ie, input bit en);
      return 16'((ps << 8) | (int'(ie) << 4) | (int'(rr) << 3) | (sel << 1) | int'(en));
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: got 0x0000 expected 0x0001");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int c; bit h;
      void'($urandom(32'd11));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      foreach (int_offs[i]) begin end
      rd('h00, v); chk("R1 mode", v, 0);
      rd('h04, v); chk("R1 ref", v, 0);
      rd('h08, v); chk("R1 cap", v, 0);
      rd('h0C, v); chk("R1 count", v, 0);
      rd('h11, v); chk("R1 event", v, 0);
      chk("R1 irq", 16'(irq), 0);

      // R2 map, capture storage, unmapped offsets
      wr('h08, 16'hBEEF); rd('h08, v); chk("R2 capture", v, 16'hBEEF);
      wr('h04, 16'h1234); rd('h04, v); chk("R2 ref", v, 16'h1234);
      wr('h00, 16'h0012); rd('h00, v); chk("R2 mode", v, 16'h0012);
      rd('h02, v); chk("R2 unmapped 02", v, 0);
      rd('h10, v); chk("R2 unmapped 10", v, 0);
      rd('h14, v); chk("R2 unmapped 14", v, 0);

      // R3 disabled write stored as written; count holds
      wait_cyc(10); rd('h0C, v); chk("R3 hold disabled", v, 0);

      // R5 system clock, P=3: 40 cycles -> 10 ticks
      wr('h04, 16'd1000);
      wr('h00, mk_mode(3, 1, 0, 0, 1));
      wait_cyc(40); rd('h0C, v); chk("R5 sys P3", v, 16'd10);
      wait_cyc(3);  rd('h0C, v); chk("R5 sys P3 before edge", v, 16'd10);
      wait_cyc(1);  rd('h0C, v); chk("R5 sys P3 next", v, 16'd11);

      // R4 divided source, P=1: 100 cycles -> 3 ticks
      wr('h00, mk_mode(1, 2, 0, 0, 1));
      wait_cyc(31); rd('h0C, v); chk("R4 slow before first", v, 0);
      wait_cyc(1);  rd('h0C, v); chk("R4 slow first", v, 1);
      wait_cyc(68); rd('h0C, v); chk("R4 slow 100", v, 3);

      // R4 stopped sources
      wr('h00, mk_mode(0, 0, 0, 0, 1));
      wait_cyc(50); rd('h0C, v); chk("R4 sel0 stop", v, 0);
      wr('h00, mk_mode(0, 3, 0, 0, 1));
      wait_cyc(50); rd('h0C, v); chk("R4 sel3 stop", v, 0);

      // R6 restart at reference 5
      wr('h04, 16'd5);
      wr('h00, mk_mode(0, 1, 1, 0, 1));
      wait_cyc(20); rd('h0C, v); chk("R6 restart count", v, 16'(20 % 6));
      rd('h11, v); chk("R8 event set", v, 16'h0002);
      chk("R9 irq masked", 16'(irq), 0);

      // stop, then R8 write-zero ignored, R9 irq on enable, W1C
      wr('h00, mk_mode(0, 0, 0, 1, 1));
      chk("R9 irq enabled", 16'(irq), 1);
      wr('h11, 16'h0000);
      rd('h11, v); chk("R8 write zero ignored", v, 16'h0002);
      chk("R8 irq stays", 16'(irq), 1);
      wr('h11, 16'h0002);
      rd('h11, v); chk("R8 w1c", v, 0);
      chk("R9 irq cleared", 16'(irq), 0);

      // R10 load while stopped
      wr('h0C, 16'hA5A5); wait_cyc(5);
      rd('h0C, v); chk("R10 load stopped", v, 16'hA5A5);

      // R7 wrap through 0xFFFF, event still flagged
      wr('h04, 16'd3);
      wr('h00, mk_mode(0, 1, 0, 1, 1));
      wr('h0C, 16'hFFF0);
      wait_cyc(19); rd('h11, v); chk("R7 no event yet", v, 0);
      wait_cyc(1);  rd('h0C, v); chk("R7 wrap count", v, 16'd4);
      rd('h11, v); chk("R7 event after wrap", v, 16'h0002);
      chk("R9 irq on wrap event", 16'(irq), 1);

      // R11 reference write restarts counter and prescaler
      wr('h00, mk_mode(1, 1, 0, 0, 1));
      wait_cyc(9);
      wr('h04, 16'd900);
      rd('h0C, v); chk("R11 restart zero", v, 0);
      wait_cyc(7); rd('h0C, v); chk("R11 after restart", v, 16'd3);

      // R3 disabling write clears control and reference
      wr('h00, 16'h0010);
      rd('h00, v); chk("R3 mode cleared", v, 0);
      rd('h04, v); chk("R3 ref cleared", v, 0);
      rd('h0C, v); c = v; wait_cyc(8);
      rd('h0C, v); chk("R3 count frozen", v, 16'(c));

      // random runs
      for (int it = 0; it < 24; it++) begin
         int ps, sel, r, n, d;
         bit rr, ie;
         ps  = int'($urandom_range(3, 0));
         sel = int'($urandom_range(2, 1));
         r   = int'($urandom_range(40, 0));
         n   = int'($urandom_range(300, 0));
         rr  = 1'($urandom_range(1, 0));
         ie  = 1'($urandom_range(1, 0));
         d   = (ps + 1) * ((sel == 2) ? 16 : 1);
         wr('h00, mk_mode(0, 0, 0, 0, 1));
         wr('h11, 16'h0003);
         wr('h04, 16'(r));
         wr('h00, mk_mode(ps, sel, rr, ie, 1));
         wait_cyc(n);
         model(0, n / d, r, rr, c, h);
         rd('h0C, v); chk("R5 R6 random count", v, 16'(c));
         rd('h11, v); chk("R8 random event", v, {14'b0, h, 1'b0});
         chk("R9 random irq", 16'(irq), 16'(ie && h));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   int int_offs[1];
endmodule